// File: doc/BRIEF.md
# Per-Channel Zero-Cross Mute Unit

This block sits in the transmit side of a serial audio port, between the sample source and the bit shifter. It watches each sample word as it heads for the shifter. For every channel whose detection is switched on, it looks for a zero crossing. A crossing is either a sign flip against that channel's last sample or a sample that is entirely zero. A crossing sets a sticky per-channel flag, and the sample that caused it is already replaced by silence.

While a flag stays set, every sample of its channel leaves the block as an all-zero word. The valid strobe and the channel index pass through unchanged, one cycle later. Software clears a flag by writing 1 to its bit. The interrupt request is raised while any flag of an enabled channel is set.

Channels 0 and 1 (left and right in I2S or two-channel PCM) can always detect. Channels 2 and up can detect only in multi-channel PCM mode, and only if they fall inside the active channel count that the TDM count field selects.

Top module: `zcm_unit`

## Requirements
- R1: Reset clears all flags, the output valid and the interrupt. It also sets every channel's stored sign to positive, so a negative first sample after reset counts as a crossing.
- R2: With detection active on channel n, a valid sample whose sign bit (the most significant bit) differs from that channel's previous valid sample sets flag bit n (`flags_o[n]`).
- R3: With detection active on channel n, a valid all-zero sample sets flag bit n, whatever the stored sign.
- R4: When `zc_en_i[n]` is 0, samples of channel n set no flag. The stored sign of channel n is still updated by every valid sample of channel n.
- R5: Detection on channels 0 and 1 needs only the enable bit. For a channel c of 2 or more it also needs `fmt_pcm_i`=1 (1 = PCM, 0 = I2S), `multi_ch_i`=1, and c below the active count. `tdm_cnt_i` values 0/1/2/3 give 2/4/6/8 active channels.
- R6: A sample on channel n leaves as all zeros if flag n was set before it arrived or if the sample itself sets flag n. Every other sample, including those on channels 5 to 7, passes through unchanged.
- R7: Each valid input sample appears on `out_valid_o`/`out_chan_o`/`out_data_o` exactly one clock later, in order, with its channel index unchanged.
- R8: Writing 1 to bit n of `flag_clr_i` clears flag n at the next edge. A sample in that same cycle is still muted, and the first sample in a later cycle passes. If a set and a clear hit the same flag in one cycle, the flag stays set.
- R9: `irq_o` is 1 exactly when some flag n is set and `zc_en_i[n]` is 1.
- R10: Clearing `zc_en_i[n]` while flag n is set leaves the flag set, and channel n stays muted. Only the interrupt contribution of that channel drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| smp_valid_i | input | 1 | Sample strobe |
| smp_chan_i | input | 3 | Channel index of the sample |
| smp_data_i | input | 16 | Two's-complement sample word |
| zc_en_i | input | 5 | Per-channel detection enable |
| fmt_pcm_i | input | 1 | 1 = PCM format, 0 = I2S |
| multi_ch_i | input | 1 | 1 = multi-channel (TDM) PCM |
| tdm_cnt_i | input | 2 | Active channel count select (2/4/6/8) |
| flag_clr_i | input | 5 | Write-1-to-clear strobe for the flags |
| out_valid_o | output | 1 | Outgoing sample strobe |
| out_chan_o | output | 3 | Outgoing channel index |
| out_data_o | output | 16 | Outgoing sample, zero when muted |
| flags_o | output | 5 | Sticky zero-cross flags, bit n for channel n |
| irq_o | output | 1 | Interrupt request |

## Verification
Some rules are checked by the assertions on every cycle. A set flag holds unless it is cleared. A flag only rises after a qualified sample of its own channel. A clear with no sample in the same cycle always takes effect. The output keeps a one-cycle latency and zeroes muted words. In I2S format the upper channels never raise a flag, and the interrupt stays low while no flag is set. Other behaviour only the bench scenarios can show: the per-channel sign history across interleaved channels, the sign tracking of disabled channels, the channel-count gating of each TDM setting, and the ordering of a clear against a set or a sample in the same cycle.

// File: rtl/zcm_pkg.sv
`timescale 1ns/1ps
package zcm_pkg;
   // width of the active-channel count
   localparam int unsigned CNT_W = 4;

   typedef enum logic {
      FMT_I2S = 1'b0,
      FMT_PCM = 1'b1
   } fmt_e;

   // TDM count code 0..3 selects 2, 4, 6 or 8 active slots
   function automatic logic [CNT_W-1:0] active_slots(input logic [1:0] code);
      return {1'b0, code, 1'b0} + CNT_W'(2);
   endfunction
endpackage

// File: rtl/zcm_qualify.sv
`timescale 1ns/1ps
module zcm_qualify
   import zcm_pkg::*;
#(
   parameter int unsigned DET_CH = 5
) (
   input  logic [DET_CH-1:0] zc_en_i,
   input  logic              fmt_pcm_i,
   input  logic              multi_ch_i,
   input  logic [1:0]        tdm_cnt_i,
   output logic [DET_CH-1:0] det_en_o
);
   logic [CNT_W-1:0] slots;
   logic             tdm_mode;

   assign slots    = active_slots(tdm_cnt_i);
   assign tdm_mode = (fmt_e'(fmt_pcm_i) == FMT_PCM) && multi_ch_i;

   for (genvar c = 0; c < DET_CH; c++) begin : g_q
      if (c < 2) begin : g_base
         // left/right slots always qualify
         assign det_en_o[c] = zc_en_i[c];
      end else begin : g_tdm
         assign det_en_o[c] = zc_en_i[c] & tdm_mode & (CNT_W'(c) < slots);
      end
   end
endmodule

// File: rtl/zcm_chan.sv
`timescale 1ns/1ps
module zcm_chan (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic hit_i,
   input  logic det_en_i,
   input  logic sign_i,
   input  logic zero_i,
   input  logic clr_i,
   output logic flag_o,
   output logic mute_o
);
   logic prev_sign_q;
   logic flag_q;
   logic trig;

   assign trig = hit_i & det_en_i & ((sign_i ^ prev_sign_q) | zero_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         prev_sign_q <= 1'b0;
         flag_q      <= 1'b0;
      end else begin
         if (hit_i) prev_sign_q <= sign_i;
         // set beats clear
         flag_q <= (flag_q & ~clr_i) | trig;
      end
   end

   assign flag_o = flag_q;
   assign mute_o = flag_q | trig;

   // R8, R10: a set flag only drops through a clear
   assert_flag_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_q && !clr_i |=> flag_q);

   // R8: clear with no sample in the same cycle always wins
   assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i && !hit_i |=> !flag_o);

   // R2, R3, R4: flag only rises after a qualified sample of this channel
   assert_flag_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !flag_o && !(hit_i && det_en_i) |=> !flag_o);
endmodule

// File: rtl/zcm_out_stage.sv
`timescale 1ns/1ps
module zcm_out_stage #(
   parameter int unsigned SAMPLE_W = 16,
   parameter int unsigned IDX_W    = 3
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                in_valid_i,
   input  logic [IDX_W-1:0]    in_chan_i,
   input  logic [SAMPLE_W-1:0] in_data_i,
   input  logic                mute_i,
   output logic                out_valid_o,
   output logic [IDX_W-1:0]    out_chan_o,
   output logic [SAMPLE_W-1:0] out_data_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         out_valid_o <= 1'b0;
         out_chan_o  <= '0;
         out_data_o  <= '0;
      end else begin
         out_valid_o <= in_valid_i;
         if (in_valid_i) begin
            out_chan_o <= in_chan_i;
            out_data_o <= mute_i ? '0 : in_data_i;
         end
      end
   end

   // R7: one cycle latency, index preserved
   assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> out_valid_o && out_chan_o == $past(in_chan_i));

   assert_no_spurious_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> !out_valid_o);

   // R6: muted words leave as silence
   assert_mute_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i && mute_i |=> out_data_o == '0);

   assert_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i && !mute_i |=> out_data_o == $past(in_data_i));
endmodule

// File: rtl/zcm_unit.sv
`timescale 1ns/1ps
module zcm_unit #(
   parameter int unsigned SAMPLE_W = 16,
   parameter int unsigned DET_CH   = 5,
   parameter int unsigned IDX_W    = 3
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                smp_valid_i,
   input  logic [IDX_W-1:0]    smp_chan_i,
   input  logic [SAMPLE_W-1:0] smp_data_i,
   input  logic [DET_CH-1:0]   zc_en_i,
   input  logic                fmt_pcm_i,
   input  logic                multi_ch_i,
   input  logic [1:0]          tdm_cnt_i,
   input  logic [DET_CH-1:0]   flag_clr_i,
   output logic                out_valid_o,
   output logic [IDX_W-1:0]    out_chan_o,
   output logic [SAMPLE_W-1:0] out_data_o,
   output logic [DET_CH-1:0]   flags_o,
   output logic                irq_o
);
   localparam int unsigned SIGN_BIT = SAMPLE_W - 1;

   if (SAMPLE_W < 2) begin : g_bad_width
      $error("zcm_unit: SAMPLE_W must be at least 2");
   end
   if (DET_CH < 2 || DET_CH > 8) begin : g_bad_ch
      $error("zcm_unit: DET_CH must lie in 2..8");
   end
   if (DET_CH > (1 << IDX_W)) begin : g_bad_idx
      $error("zcm_unit: IDX_W too narrow for DET_CH");
   end

   logic [DET_CH-1:0] det_en;
   logic [DET_CH-1:0] mute_vec;
   logic [DET_CH-1:0] hit_vec;
   logic              sample_zero;
   logic              sel_mute;

   assign sample_zero = (smp_data_i == '0);

   zcm_qualify #(.DET_CH(DET_CH)) u_qual (
      .zc_en_i   (zc_en_i),
      .fmt_pcm_i (fmt_pcm_i),
      .multi_ch_i(multi_ch_i),
      .tdm_cnt_i (tdm_cnt_i),
      .det_en_o  (det_en)
   );

   for (genvar c = 0; c < DET_CH; c++) begin : g_ch
      assign hit_vec[c] = smp_valid_i && (smp_chan_i == IDX_W'(c));

      zcm_chan u_chan (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .hit_i   (hit_vec[c]),
         .det_en_i(det_en[c]),
         .sign_i  (smp_data_i[SIGN_BIT]),
         .zero_i  (sample_zero),
         .clr_i   (flag_clr_i[c]),
         .flag_o  (flags_o[c]),
         .mute_o  (mute_vec[c])
      );
   end

   // channels without a detector never mute
   assign sel_mute = |(hit_vec & mute_vec);

   zcm_out_stage #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_out (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_valid_i (smp_valid_i),
      .in_chan_i  (smp_chan_i),
      .in_data_i  (smp_data_i),
      .mute_i     (sel_mute),
      .out_valid_o(out_valid_o),
      .out_chan_o (out_chan_o),
      .out_data_o (out_data_o)
   );

   assign irq_o = |(flags_o & zc_en_i);

   // R9: no flag, no interrupt
   assert_irq_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags_o == '0 |-> !irq_o);

   // R5: in I2S format the upper channels never raise a flag
   if (DET_CH > 2) begin : g_chk_upper
      assert_i2s_upper_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !fmt_pcm_i && flags_o[DET_CH-1:2] == '0 |=> flags_o[DET_CH-1:2] == '0);
   end
endmodule

// File: tb/sim_zcm_unit.sv
`timescale 1ns/1ps
module sim_zcm_unit;
   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          s_valid = 1'b0;
   logic [2:0]    s_chan = '0;
   logic [W-1:0]  s_data = '0;
   logic [4:0]    en = '0;
   logic          pcm = 1'b0;
   logic          multi = 1'b0;
   logic [1:0]    tdm = '0;
   logic [4:0]    clr = '0;
   logic          o_valid;
   logic [2:0]    o_chan;
   logic [W-1:0]  o_data;
   logic [4:0]    flags;
   logic          irq;

   always #5 clk = ~clk;

   zcm_unit u0 (
      .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(s_valid), .smp_chan_i(s_chan),
      .smp_data_i(s_data), .zc_en_i(en), .fmt_pcm_i(pcm), .multi_ch_i(multi),
      .tdm_cnt_i(tdm), .flag_clr_i(clr), .out_valid_o(o_valid), .out_chan_o(o_chan),
      .out_data_o(o_data), .flags_o(flags), .irq_o(irq)
   );

   typedef struct packed { logic [2:0] ch; logic [W-1:0] d; } item_t;
   item_t      sb[$];
   item_t      got;
   logic       m_prev [8];
   logic [4:0] m_flag;
   int         total = 0;
   int         bad = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic bit qual(input int c);
      if (c < 2) return 1'b1;
      if (c > 4) return 1'b0;
      return pcm && multi && (c < 2 * (int'(tdm) + 1));
   endfunction

   // one cycle of stimulus; called and returns at a falling edge
   task automatic drive(input bit v, input int ch, input logic [W-1:0] d,
                        input logic [4:0] cl, input string req);
      logic [4:0] trig;
      bit         mute;
      item_t      it;
      trig = '0;
      mute = 1'b0;
      if (v) begin
         if (ch < 5 && en[ch] && qual(ch) && (d[W-1] != m_prev[ch] || d == '0))
            trig[ch] = 1'b1;
         if (ch < 5) mute = m_flag[ch] | trig[ch];
         m_prev[ch] = d[W-1];
         it.ch = 3'(ch);
         it.d  = mute ? '0 : d;
         sb.push_back(it);
      end
      m_flag  = (m_flag & ~cl) | trig;
      s_valid = v;
      s_chan  = 3'(ch);
      s_data  = d;
      clr     = cl;
      @(negedge clk);
      s_valid = 1'b0;
      clr     = '0;
      check(flags === m_flag, req, "flags", 32'(flags), 32'(m_flag));
      check(irq === |(m_flag & en), "R9", "irq", 32'(irq), 32'(|(m_flag & en)));
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && o_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R7", "unexpected output", 32'(o_chan), 32'hx);
         end else begin
            got = sb.pop_front();
            check(o_chan === got.ch, "R7", "chan", 32'(o_chan), 32'(got.ch));
            check(o_data === got.d, "R6", "data", 32'(o_data), 32'(got.d));
         end
      end
   end

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      m_flag = '0;
      for (int i = 0; i < 8; i++) m_prev[i] = 1'b0;
      sb.delete();
      rst_n = 1'b1;
      @(negedge clk);
      check(flags === '0, "R1", "flags after reset", 32'(flags), 0);
      check(irq === 1'b0, "R1", "irq after reset", 32'(irq), 0);
      check(o_valid === 1'b0, "R1", "valid after reset", 32'(o_valid), 0);
   endtask

   initial begin
      #1_000_000;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      en = 5'b11111;
      // R1: stored sign positive after reset, first negative sample crosses
      drive(1, 0, 16'h1234, '0, "R1");
      drive(1, 0, 16'h8001, '0, "R1");
      drive(1, 0, 16'h0111, '0, "R6");
      drive(1, 1, 16'h4000, '0, "R6");
      // R8: clear in a cycle with a sample of that channel: still muted
      drive(1, 0, 16'h0222, 5'b00001, "R8");
      drive(1, 0, 16'h0333, '0, "R8");
      // R2: negative then positive on channel 1
      drive(1, 1, 16'hC000, '0, "R2");
      drive(1, 1, 16'hC001, 5'b00010, "R2");
      drive(1, 1, 16'h7FFF, '0, "R2");
      drive(0, 0, '0, 5'b00011, "R8");
      // R3: zero sample, sign unchanged
      drive(1, 0, 16'h0000, '0, "R3");
      drive(0, 0, '0, 5'b00001, "R8");
      // R4: disabled channel tracks sign but does not flag
      en = 5'b11110;
      drive(1, 0, 16'h9000, '0, "R4");
      drive(1, 0, 16'h0000, '0, "R4");
      en = 5'b11111;
      drive(1, 0, 16'hA000, '0, "R4");
      drive(1, 0, 16'hA001, '0, "R4");
      // R5: upper channels in I2S do not detect
      drive(1, 2, 16'h8000, '0, "R5");
      drive(1, 3, 16'h0000, '0, "R5");
      drive(1, 4, 16'hF000, '0, "R5");
      pcm = 1'b1;
      drive(1, 2, 16'h0001, '0, "R5");
      drive(1, 2, 16'h0000, '0, "R5");
      multi = 1'b1;
      tdm = 2'd1;
      drive(1, 3, 16'h8000, '0, "R5");
      drive(1, 4, 16'h8000, '0, "R5");
      drive(1, 4, 16'h0000, '0, "R5");
      tdm = 2'd2;
      drive(1, 4, 16'h7000, '0, "R5");
      drive(1, 4, 16'h8000, '0, "R5");
      tdm = 2'd3;
      drive(1, 6, 16'h0000, '0, "R6");
      drive(1, 7, 16'h8765, '0, "R6");
      drive(1, 5, 16'h1357, '0, "R6");
      drive(0, 0, '0, 5'b11111, "R8");
      // R8: set and clear in the same cycle, set wins
      drive(1, 2, 16'hFFFF, 5'b00100, "R8");
      drive(1, 2, 16'hFFFE, 5'b00100, "R8");
      drive(1, 2, 16'h0ABC, '0, "R8");
      drive(0, 0, '0, 5'b00100, "R8");
      // R10: disabling keeps flag and mute, only irq drops
      drive(1, 3, 16'h1000, '0, "R10");
      drive(1, 3, 16'h9000, '0, "R10");
      en = 5'b10111;
      drive(0, 0, '0, '0, "R10");
      drive(1, 3, 16'h2222, '0, "R10");
      drive(1, 1, 16'h1111, '0, "R9");
      en = 5'b11111;
      drive(0, 0, '0, 5'b01000, "R10");
      drive(1, 3, 16'h2223, '0, "R10");
      // R7: back-to-back interleaved channels
      for (int k = 0; k < 24; k++)
         drive(1, k % 8, 16'(k * 16'h1F3B), '0, "R7");
      drive(0, 0, '0, 5'b11111, "R8");
      // R1: reset in the middle of a run clears flags and stored signs
      drive(1, 1, 16'h8000, '0, "R1");
      do_reset();
      en = 5'b00011;
      drive(1, 1, 16'h8000, '0, "R1");
      drive(0, 0, '0, '0, "R7");
      check(sb.size() == 0, "R7", "scoreboard drained", 32'(sb.size()), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule